// File: doc/BRIEF.md
# Microframe Mask Transaction Selector

This block decides, once per microframe, whether a periodic queue head should be scheduled in the current slot of the frame. It keeps its own three-bit microframe position counter, which advances on every microframe tick. On each tick it uses the counter value to pick one bit from each of two 8-bit masks: a start mask and a complete-split mask. It then registers the candidate decisions for the rest of the microframe.

The start mask applies at every endpoint speed. The complete-split mask applies only to low- or full-speed endpoints that sit on the periodic schedule. For those endpoints, a complete candidate also needs the queue head to be active and its split state to be in the complete phase. The block also reports whether the queue head is an interrupt endpoint and whether it is a split interrupt endpoint. It raises an error flag for mask combinations whose behaviour is undefined. A scheduler samples the registered outputs after each tick. Issuing the transactions themselves is the job of other logic.

Top module: `uframe_sched_sel`

## Requirements
- R1: After reset the microframe position reads 0 and every registered output (start, complete, interrupt, split interrupt, error) reads 0.
- R2: The microframe position increments by one on each cycle with `tick_i` high and wraps from 7 to 0. It holds when `tick_i` is low.
- R3: On a tick, `start_cand_o` is loaded with the start-mask bit selected by the microframe position before that tick, with bit n of the mask belonging to position n. It becomes visible the cycle after the tick.
- R4: The complete-split mask has no effect unless `speed_i` is 2'b00 (full speed) or 2'b01 (low speed) and `periodic_i` is high. Otherwise `cmpl_cand_o` is loaded with 0 and the mask never raises the error flag.
- R5: When the complete-split mask applies, `cmpl_cand_o` is loaded with 1 only if the indexed complete-mask bit, `active_i` and `cphase_i` (split state in the complete phase) are all 1.
- R6: On a tick, `intr_ep_o` is loaded with 1 exactly when the start mask is non-zero.
- R7: On a tick, `split_intr_o` is loaded with 1 exactly when the start mask is non-zero and the speed code is 2'b00 or 2'b01.
- R8: On a tick, `mask_err_o` is loaded with 1 when either of two conditions holds: the complete-split mask applies (as in R4) and is zero, or `periodic_i` is high and the start mask is zero.
- R9: Speed code 2'b11 (2'b10 is high speed) is reserved. On a tick with code 2'b11, both candidate outputs are loaded with 0.
- R10: All registered outputs hold their values between ticks, whatever the inputs do. With several mask bits set, a queue head is selected in each of the matching microframes of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Microframe tick; evaluate and advance position |
| smask_i | input | 8 | Start (interrupt schedule) mask |
| cmask_i | input | 8 | Complete-split mask |
| speed_i | input | 2 | Endpoint speed: 00 full, 01 low, 10 high, 11 reserved |
| periodic_i | input | 1 | Queue head is on the periodic schedule |
| active_i | input | 1 | Queue head transfer is active |
| cphase_i | input | 1 | Split state is in the complete phase |
| uframe_o | output | 3 | Current microframe position |
| start_cand_o | output | 1 | Start/normal transaction candidate |
| cmpl_cand_o | output | 1 | Complete-split candidate |
| intr_ep_o | output | 1 | Interrupt endpoint indication |
| split_intr_o | output | 1 | Split-transaction interrupt endpoint |
| mask_err_o | output | 1 | Undefined mask combination detected |

## Verification
Sparse and dense start masks are each swept over a full frame of eight ticks. This separates a correct position-to-bit mapping from off-by-one or bit-reversed indexing, and it shows selection in several microframes. Complete-split masks are swept at all four speed codes, with and without the periodic flag and with active and complete-phase each dropped in turn. This tells whether the mask gating and the qualifiers are each honoured. Zero masks in and out of their "in use" context separate a correct error condition from one that fires too often. Changing the inputs between ticks confirms that the outputs and the position hold.

// File: rtl/uframe_sched_sel.sv
module uframe_sched_sel #(
  parameter int MASK_W = 8,
  localparam int IDX_W = $clog2(MASK_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [MASK_W-1:0] smask_i,
  input  logic [MASK_W-1:0] cmask_i,
  input  logic [1:0]        speed_i,
  input  logic              periodic_i,
  input  logic              active_i,
  input  logic              cphase_i,
  output logic [IDX_W-1:0]  uframe_o,
  output logic              start_cand_o,
  output logic              cmpl_cand_o,
  output logic              intr_ep_o,
  output logic              split_intr_o,
  output logic              mask_err_o
);

  logic [IDX_W-1:0] pos_q;
  logic slow_spd, rsvd_spd, csplit_use, s_hit, c_hit, s_any, c_any;

  assign slow_spd   = (speed_i == 2'b00) || (speed_i == 2'b01);
  assign rsvd_spd   = (speed_i == 2'b11);
  assign csplit_use = slow_spd && periodic_i;
  assign s_hit      = smask_i[pos_q];
  assign c_hit      = cmask_i[pos_q];
  assign s_any      = |smask_i;
  assign c_any      = |cmask_i;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      pos_q        <= '0;
      start_cand_o <= 1'b0;
      cmpl_cand_o  <= 1'b0;
      intr_ep_o    <= 1'b0;
      split_intr_o <= 1'b0;
      mask_err_o   <= 1'b0;
    end else if (tick_i) begin
      pos_q        <= pos_q + 1'b1;
      start_cand_o <= s_hit && !rsvd_spd;
      cmpl_cand_o  <= csplit_use && c_hit && active_i && cphase_i;
      intr_ep_o    <= s_any;
      split_intr_o <= s_any && slow_spd;
      mask_err_o   <= (csplit_use && !c_any) || (periodic_i && !s_any);
    end
  end

  assign uframe_o = pos_q;

endmodule

module uframe_sched_sel_chk #(
  parameter int MASK_W = 8,
  localparam int IDX_W = $clog2(MASK_W)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic [MASK_W-1:0] smask_i,
  input logic [MASK_W-1:0] cmask_i,
  input logic [1:0]        speed_i,
  input logic              periodic_i,
  input logic [IDX_W-1:0]  uframe_o,
  input logic              start_cand_o,
  input logic              cmpl_cand_o,
  input logic              intr_ep_o,
  input logic              split_intr_o,
  input logic              mask_err_o
);

  a_r2_pos_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> uframe_o == IDX_W'($past(uframe_o) + 1'b1));

  a_r10_hold_between_ticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(uframe_o) && $stable(start_cand_o) && $stable(cmpl_cand_o)
                && $stable(intr_ep_o) && $stable(split_intr_o) && $stable(mask_err_o));

  a_r9_reserved_speed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && speed_i == 2'b11 |=> !start_cand_o && !cmpl_cand_o);

  a_r4_cmask_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && (!periodic_i || speed_i[1]) |=> !cmpl_cand_o);

  a_r8_zero_smask_periodic: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && periodic_i && smask_i == '0 |=> mask_err_o);

  a_r6_intr_zero_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && smask_i == '0 |=> !intr_ep_o && !split_intr_o && !start_cand_o);

  a_r7_split_implies_intr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    split_intr_o |-> intr_ep_o);

endmodule

bind uframe_sched_sel uframe_sched_sel_chk #(.MASK_W(MASK_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .smask_i(smask_i),
  .cmask_i(cmask_i), .speed_i(speed_i), .periodic_i(periodic_i),
  .uframe_o(uframe_o), .start_cand_o(start_cand_o), .cmpl_cand_o(cmpl_cand_o),
  .intr_ep_o(intr_ep_o), .split_intr_o(split_intr_o), .mask_err_o(mask_err_o)
);

// File: tb/uframe_sched_sel_tb_top.sv
module uframe_sched_sel_tb_top;

  typedef struct packed {
    logic [2:0] uf;
    logic st, cc, ie, si, er;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic [7:0] smask = '0, cmask = '0;
  logic [1:0] speed = 2'b10;
  logic periodic = 1'b0, active = 1'b0, cphase = 1'b0;
  logic [2:0] uf;
  logic st, cc, ie, si, er;

  int checks = 0, fails = 0;
  logic [2:0] tb_pos = '0;
  exp_t last_exp = '0;
  exp_t q[$];
  bit done = 0;

  always #4 clk = ~clk;

  uframe_sched_sel dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .smask_i(smask), .cmask_i(cmask),
    .speed_i(speed), .periodic_i(periodic), .active_i(active), .cphase_i(cphase),
    .uframe_o(uf), .start_cand_o(st), .cmpl_cand_o(cc), .intr_ep_o(ie),
    .split_intr_o(si), .mask_err_o(er)
  );

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cmp_all(input exp_t e, input string ctx);
    chk({"R2 uframe ", ctx}, uf, e.uf);
    chk({"R3/R9/R10 start ", ctx}, {2'b0, st}, {2'b0, e.st});
    chk({"R4/R5/R9 cmpl ", ctx}, {2'b0, cc}, {2'b0, e.cc});
    chk({"R6 intr ", ctx}, {2'b0, ie}, {2'b0, e.ie});
    chk({"R7 split ", ctx}, {2'b0, si}, {2'b0, e.si});
    chk({"R8 err ", ctx}, {2'b0, er}, {2'b0, e.er});
  endtask

  // Expected values from the requirements
  function automatic exp_t model(input logic [2:0] p);
    exp_t e;
    logic slow = (speed == 2'b00) || (speed == 2'b01);
    logic use_c = slow && periodic;
    e.uf = p + 3'd1;
    e.st = (speed != 2'b11) && smask[p];
    e.cc = use_c && cmask[p] && active && cphase;
    e.ie = (smask != 8'h00);
    e.si = (smask != 8'h00) && slow;
    e.er = (use_c && cmask == 8'h00) || (periodic && smask == 8'h00);
    return e;
  endfunction

  task automatic do_tick(input logic [7:0] sm, input logic [7:0] cm, input logic [1:0] sp,
                         input logic per, input logic act, input logic cph);
    exp_t e;
    @(posedge clk); #1;
    smask = sm; cmask = cm; speed = sp; periodic = per; active = act; cphase = cph;
    tick = 1'b1;
    e = model(tb_pos);
    @(posedge clk); #1;
    tick = 1'b0;
    tb_pos = tb_pos + 3'd1;
    last_exp = e;
    q.push_back(e);
  endtask

  task automatic sweep(input logic [7:0] sm, input logic [7:0] cm, input logic [1:0] sp,
                       input logic per, input logic act, input logic cph);
    for (int i = 0; i < 8; i++) do_tick(sm, cm, sp, per, act, cph);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) cmp_all(q.pop_front(), "tick");
  end

  initial begin
    #(8 * 20000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    cmp_all('0, "R1 reset");

    // R3 R10: sparse and dense start masks, high speed periodic
    sweep(8'b0000_0101, 8'h00, 2'b10, 1'b1, 1'b0, 1'b0);
    sweep(8'b1011_0110, 8'hff, 2'b10, 1'b1, 1'b1, 1'b1);
    // R5 R7: low and full speed periodic complete-split
    sweep(8'b0000_0001, 8'b0001_1100, 2'b01, 1'b1, 1'b1, 1'b1);
    sweep(8'b0000_0010, 8'b1110_0000, 2'b00, 1'b1, 1'b1, 1'b1);
    // R5: qualifiers dropped
    sweep(8'b0000_0001, 8'hff, 2'b00, 1'b1, 1'b0, 1'b1);
    sweep(8'b0000_0001, 8'hff, 2'b01, 1'b1, 1'b1, 1'b0);
    // R4: not periodic, or high speed
    sweep(8'h00, 8'hff, 2'b00, 1'b0, 1'b1, 1'b1);
    sweep(8'h11, 8'h00, 2'b10, 1'b1, 1'b1, 1'b1);
    sweep(8'h00, 8'h00, 2'b01, 1'b0, 1'b1, 1'b1);
    // R8: zero masks in use
    sweep(8'h00, 8'h0f, 2'b00, 1'b1, 1'b1, 1'b1);
    sweep(8'h40, 8'h00, 2'b01, 1'b1, 1'b1, 1'b1);
    // R9: reserved speed
    sweep(8'hff, 8'hff, 2'b11, 1'b1, 1'b1, 1'b1);

    // R10: outputs and position hold between ticks
    do_tick(8'h01, 8'h01, 2'b00, 1'b1, 1'b1, 1'b1);
    @(posedge clk); #1;
    smask = 8'h00; cmask = 8'h00; speed = 2'b11; periodic = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    cmp_all(last_exp, "R10 hold");

    repeat (3) @(posedge clk);
    @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule